// File: doc/BRIEF.md
# Peripheral Module Gating Wrapper

This block sits between the register bus and one peripheral core and decides when that core gets a clock and when its registers can be reached. Three control bits drive it. A module-off bit sits in its own control register, which can always be reached. A run bit and an idle-stop bit sit in the peripheral's control register, which the wrapper holds. From these bits and the system idle flag, the block produces a clock enable and a functional enable for the core. It also gates the core's register write strobe and masks the read data that returns to the bus.

There are two levels of shutdown. The module-off bit removes every clock from the core. It also holds the core and its control register in their default state, blocks every write to them, and makes reads of them return zero. Clearing the run bit is the lighter level: the core stops, but its registers stay fully readable and writable. Setting the idle-stop bit also stops the core while the system is idle. By default that bit is clear, so the core keeps running through idle.

Top module: `pmg_wrap`

## Requirements
- R1: After a synchronous active-low reset, the module-off bit, the run bit and the idle-stop bit are all 0. The clock enable and the functional enable are both 0.
- R2: The mode register is at address 0, and its bit 0 is the module-off bit. It can be written and read back at any time, including while the module-off bit is set.
- R3: The clock enable is 1 exactly when the module-off bit is 0, the run bit is 1, and the system is not both idle and set to stop in idle.
- R4: While the module-off bit is 1, the block ignores writes to the control register (address 1) and to the core's registers (addresses 2 and above). The core write strobe stays low.
- R5: While the module-off bit is 1, reads of address 1 and of addresses 2 and above return all zeros.
- R6: While the module-off bit is 1, the control register is forced to 0. After the bit is cleared, the control register stays 0 until software writes it.
- R7: While the module-off bit is 0, the control register and the core's registers can be read and written whatever the value of the run bit. A write to address 2 or above pulses the core write strobe in that cycle.
- R8: While the idle-stop bit (bit 13 of address 1) is 1 and the system idle flag is high, the core receives no clock. While the idle-stop bit is 0, the core keeps its clock through idle.
- R9: The functional enable equals the run bit (bit 15 of address 1) AND NOT the module-off bit. The idle flag does not affect it.
- R10: Read data is 0 whenever the read strobe is low. Bits that are not implemented in the mode register or the control register read as 0.
- R11: The core clear output is high in exactly those cycles in which the module-off bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_idle | input | 1 | High while the system is in idle |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| periph_rdata | input | DATA_W | Read data from the core's registers |
| periph_clk_en | output | 1 | Clock enable for the core |
| periph_fen | output | 1 | Functional enable for the core |
| periph_wr | output | 1 | Gated write strobe to the core's registers |
| periph_clr | output | 1 | Holds the core's registers at their defaults |
| bus_rdata | output | DATA_W | Masked read data back to the bus |

## Verification
A wrong module-off bit shows at once on the clock enable, on the clear output and on a masked read. A wrong control bit shows on the clock enable and on the functional enable in the same cycle. The core is a counter, and its value is read through the bus. A clock that is wrongly gated therefore shows as a count that moves or stays still on the next read, a few cycles later. A leaked write, or a control register that is not cleared, stays hidden while the module is off. It appears on the first read after the module-off bit is cleared.

// File: rtl/pmg_pkg.sv
// Shared types for the peripheral module gating wrapper.
// Assumes: the control register holds only the run and idle-stop bits.
package pmg_pkg;

    // Decoded contents of the peripheral control register
    typedef struct packed {
        logic run;
        logic istop;
    } pmg_ctl_t;

    localparam pmg_ctl_t PMG_CTL_DEFAULT = '{run: 1'b0, istop: 1'b0};

    // Address classes seen by the wrapper
    typedef enum logic [1:0] {
        PMG_SEL_MODE = 2'd0,
        PMG_SEL_CTL  = 2'd1,
        PMG_SEL_CORE = 2'd2
    } pmg_sel_e;

endpackage

// File: rtl/pmg_mode_reg.sv
// Module-off register. It is always accessible, and OFF_BIT holds the
// module-off flag. Assumes a single-cycle bus_wr strobe.
module pmg_mode_reg #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int MODE_ADDR = 0,
    parameter int OFF_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              mod_off
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

    logic hit_wr;

    // Decode a write to the mode register
    always_comb hit_wr = bus_wr && (bus_addr == MODE_A);

    // Hold the module-off flag
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_off <= 1'b0;
        else if (hit_wr) mod_off <= bus_wdata[OFF_BIT];
    end

    a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == MODE_A) |=> (mod_off == $past(bus_wdata[OFF_BIT])));

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == MODE_A) |=> $stable(mod_off));
endmodule

// File: rtl/pmg_ctl_reg.sv
// Peripheral control register that holds the run and idle-stop bits.
// Writes are taken only while the module is on. While it is off, the
// register is forced to its default. Assumes a single-cycle bus_wr strobe.
module pmg_ctl_reg
    import pmg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int CTL_ADDR  = 1,
    parameter int RUN_BIT   = 15,
    parameter int ISTOP_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_off,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output pmg_ctl_t          ctl
);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

    logic     hit_wr;
    pmg_ctl_t ctl_next;

    // Decode a write to the control register
    always_comb hit_wr = bus_wr && (bus_addr == CTL_A);

    // Pick the next control value: clear when off, load on a write, else hold
    always_comb begin
        ctl_next = ctl;
        if (mod_off) begin
            ctl_next = PMG_CTL_DEFAULT;
        end else if (hit_wr) begin
            ctl_next.run   = bus_wdata[RUN_BIT];
            ctl_next.istop = bus_wdata[ISTOP_BIT];
        end
    end

    // Control register flops
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= PMG_CTL_DEFAULT;
        else        ctl <= ctl_next;
    end

    a_r6_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        mod_off |=> (ctl == PMG_CTL_DEFAULT));

    a_r4_ctl_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_off && bus_wr && bus_addr == CTL_A) |=> (ctl == PMG_CTL_DEFAULT));

    a_r7_ctl_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_off && bus_wr && bus_addr == CTL_A) |=>
        (ctl.run == $past(bus_wdata[RUN_BIT]) && ctl.istop == $past(bus_wdata[ISTOP_BIT])));
endmodule

// File: rtl/pmg_gate.sv
// Combines the module-off flag, the control bits and the system idle flag
// into the clock enable and the functional enable for the core.
// Assumes sys_idle is synchronous to clk.
module pmg_gate
    import pmg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sys_idle,
    input  logic     mod_off,
    input  pmg_ctl_t ctl,
    output logic     clk_en,
    output logic     fen
);
    logic idle_hold;

    // The core is held in idle only if it was told to stop there
    always_comb idle_hold = sys_idle && ctl.istop;

    // Functional enable ignores idle
    always_comb fen = ctl.run && !mod_off;

    // The clock runs only when the core is enabled and not held in idle
    always_comb clk_en = fen && !idle_hold;

    a_r8_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_idle && ctl.istop) |-> !clk_en);

    a_r1_off_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
        mod_off |-> (!clk_en && !fen));

    a_r9_clock_needs_fen: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> fen);

    a_r8_idle_runs_by_default: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.run && !ctl.istop && !mod_off) |-> clk_en);
endmodule

// File: rtl/pmg_bus_mask.sv
// Address decode and access masking. It gates the core write strobe,
// builds the read images of the mode and control registers, and returns
// zero for blocked reads or when there is no read strobe.
// Assumes periph_rdata is valid in the same cycle as bus_rd.
module pmg_bus_mask
    import pmg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int MODE_ADDR = 0,
    parameter int CTL_ADDR  = 1,
    parameter int OFF_BIT   = 0,
    parameter int RUN_BIT   = 15,
    parameter int ISTOP_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              mod_off,
    input  pmg_ctl_t          ctl,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              periph_wr,
    output logic              periph_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_ADDR);

    pmg_sel_e          sel;
    logic [DATA_W-1:0] mode_img;
    logic [DATA_W-1:0] ctl_img;

    // Sort the address into mode, control or core space
    always_comb begin
        if (bus_addr == MODE_A)     sel = PMG_SEL_MODE;
        else if (bus_addr == CTL_A) sel = PMG_SEL_CTL;
        else                        sel = PMG_SEL_CORE;
    end

    // Build read images bit by bit; unimplemented bits read as zero
    for (genvar b = 0; b < DATA_W; b++) begin : g_img
        if (b == OFF_BIT) begin : g_off
            assign mode_img[b] = mod_off;
        end else begin : g_mz
            assign mode_img[b] = 1'b0;
        end
        if (b == RUN_BIT) begin : g_run
            assign ctl_img[b] = ctl.run;
        end else if (b == ISTOP_BIT) begin : g_ist
            assign ctl_img[b] = ctl.istop;
        end else begin : g_cz
            assign ctl_img[b] = 1'b0;
        end
    end

    // Pass core writes only while the module is on
    always_comb periph_wr = bus_wr && (sel == PMG_SEL_CORE) && !mod_off;

    // Hold the core at its defaults while the module is off
    always_comb periph_clr = mod_off;

    // Select and mask read data
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                PMG_SEL_MODE: bus_rdata = mode_img;
                PMG_SEL_CTL:  bus_rdata = mod_off ? '0 : ctl_img;
                default:      bus_rdata = mod_off ? '0 : periph_rdata;
            endcase
        end
    end

    a_r4_no_core_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        mod_off |-> !periph_wr);

    a_r5_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_off && bus_addr != MODE_A) |-> (bus_rdata == '0));

    a_r10_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    a_r7_core_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_off && bus_wr && bus_addr != MODE_A && bus_addr != CTL_A) |-> periph_wr);
endmodule

// File: rtl/pmg_wrap.sv
// Peripheral module gating wrapper (top level). It ties together the
// module-off register, the control register, the clock-gating decision
// and the bus masking for one peripheral core. Assumes a synchronous bus
// whose write and read strobes are single-cycle and whose reads complete
// in the same cycle.
module pmg_wrap
    import pmg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int MODE_ADDR = 0,
    parameter int CTL_ADDR  = 1,
    parameter int OFF_BIT   = 0,
    parameter int RUN_BIT   = 15,
    parameter int ISTOP_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_idle,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              periph_clk_en,
    output logic              periph_fen,
    output logic              periph_wr,
    output logic              periph_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic     mod_off;
    pmg_ctl_t ctl;

    pmg_mode_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MODE_ADDR(MODE_ADDR), .OFF_BIT(OFF_BIT)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mod_off(mod_off)
    );

    pmg_ctl_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR),
        .RUN_BIT(RUN_BIT), .ISTOP_BIT(ISTOP_BIT)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .mod_off(mod_off), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .ctl(ctl)
    );

    pmg_gate u_gate (
        .clk(clk), .rst_n(rst_n), .sys_idle(sys_idle), .mod_off(mod_off),
        .ctl(ctl), .clk_en(periph_clk_en), .fen(periph_fen)
    );

    pmg_bus_mask #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR),
        .CTL_ADDR(CTL_ADDR), .OFF_BIT(OFF_BIT), .RUN_BIT(RUN_BIT),
        .ISTOP_BIT(ISTOP_BIT)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .mod_off(mod_off), .ctl(ctl),
        .periph_rdata(periph_rdata), .periph_wr(periph_wr),
        .periph_clr(periph_clr), .bus_rdata(bus_rdata)
    );

    a_r11_clear_follows_off: assert property (@(posedge clk) disable iff (!rst_n)
        periph_clr |-> (!periph_clk_en && !periph_wr));
endmodule

// File: tb/sim_pmg_wrap.sv
module sim_pmg_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_idle = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] periph_rdata;
    logic        periph_clk_en, periph_fen, periph_wr, periph_clr;
    logic [15:0] bus_rdata;
    logic [15:0] cnt;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    pmg_wrap u0 (
        .clk(clk), .rst_n(rst_n), .sys_idle(sys_idle), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .periph_rdata(periph_rdata), .periph_clk_en(periph_clk_en),
        .periph_fen(periph_fen), .periph_wr(periph_wr), .periph_clr(periph_clr),
        .bus_rdata(bus_rdata)
    );

    // Stand-in core: a counter loaded through address 2
    always_ff @(posedge clk) begin
        if (!rst_n || periph_clr)            cnt <= '0;
        else if (periph_wr && bus_addr == 2) cnt <= bus_wdata;
        else if (periph_clk_en)              cnt <= cnt + 16'd1;
    end
    assign periph_rdata = cnt;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // {mode_off, run, istop, idle, exp_clk_en, exp_fen}
    localparam logic [5:0] VEC [10] = '{
        6'b0000_00, 6'b0011_00, 6'b0100_11, 6'b0101_11, 6'b0110_11,
        6'b0111_01, 6'b0001_00, 6'b0010_00, 6'b1100_00, 6'b1111_00
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, d2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 clk_en", {15'b0, periph_clk_en}, 16'h0);
        chk("R1 fen", {15'b0, periph_fen}, 16'h0);
        rd(4'd0, d); chk("R1 mode reg", d, 16'h0000);
        rd(4'd1, d); chk("R1 ctl reg", d, 16'h0000);

        // Vector table: R3, R8, R9, R11
        foreach (VEC[i]) begin
            wr(4'd0, 16'h0000);
            wr(4'd1, {VEC[i][4], 1'b0, VEC[i][3], 13'b0});
            wr(4'd0, {15'b0, VEC[i][5]});
            @(negedge clk);
            sys_idle = VEC[i][2];
            #1;
            chk("R3 clk_en vec", {15'b0, periph_clk_en}, {15'b0, VEC[i][1]});
            chk("R9 fen vec", {15'b0, periph_fen}, {15'b0, VEC[i][0]});
            chk("R11 clr vec", {15'b0, periph_clr}, {15'b0, VEC[i][5]});
        end
        sys_idle = 1'b0;

        // R2 / R10: the mode register can be reached while off; unused bits read 0
        wr(4'd0, 16'hFFFF);
        rd(4'd0, d); chk("R2 mode read while off", d, 16'h0001);
        #1 chk("R10 no strobe zero", bus_rdata, 16'h0000);

        // R4 / R5: writes blocked and reads zero while off
        wr(4'd1, 16'hFFFF);
        wr(4'd2, 16'h1234);
        rd(4'd1, d); chk("R5 ctl read off", d, 16'h0000);
        rd(4'd2, d); chk("R5 core read off", d, 16'h0000);
        wr(4'd0, 16'h0000);
        rd(4'd1, d); chk("R4 ctl write ignored", d, 16'h0000);
        rd(4'd2, d); chk("R4 core write ignored", d, 16'h0000);

        // R7: access with run cleared; the core does not advance
        wr(4'd1, 16'h2000);
        rd(4'd1, d); chk("R7 ctl readback", d, 16'h2000);
        chk("R7 clk_en off", {15'b0, periph_clk_en}, 16'h0);
        wr(4'd2, 16'h00AB);
        repeat (3) @(negedge clk);
        rd(4'd2, d); chk("R7 core readback held", d, 16'h00AB);

        // R5 / R6: going off hides the data and clears it; it stays cleared after
        wr(4'd0, 16'h0001);
        rd(4'd2, d); chk("R5 core hidden", d, 16'h0000);
        wr(4'd0, 16'h0000);
        rd(4'd2, d); chk("R6 core cleared", d, 16'h0000);
        rd(4'd1, d); chk("R6 ctl stays default", d, 16'h0000);

        // R8: with idle-stop set and idle high, the counter freezes
        wr(4'd1, 16'hA000);
        wr(4'd2, 16'h0005);
        repeat (2) @(negedge clk);
        rd(4'd2, d); chk("R3 core advancing", {15'b0, (d > 16'h0005)}, 16'h0001);
        @(negedge clk); sys_idle = 1'b1;
        rd(4'd2, d);
        repeat (4) @(negedge clk);
        rd(4'd2, d2); chk("R8 frozen in idle", d2, d);
        // R8: with idle-stop clear, the counter keeps running in idle
        wr(4'd1, 16'h8000);
        rd(4'd2, d);
        repeat (3) @(negedge clk);
        rd(4'd2, d2); chk("R8 runs in idle", {15'b0, (d2 != d)}, 16'h0001);
        chk("R9 fen in idle", {15'b0, periph_fen}, 16'h0001);
        sys_idle = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule